// File: doc/BRIEF.md
# Bit Test-and-Modify Memory Unit

This unit carries out a read-modify-write on one byte in memory, steered by an accumulator value. It handles two operations. The set variant ORs the accumulator into the byte. The clear variant removes from the byte every bit that is set in the accumulator.

An operation starts from an operand pointer. The unit fetches a two-byte absolute address through its single memory port, low byte first. It then reads the target byte and sets the N and Z flags by comparing the accumulator with that byte. Next it reads the same byte a second time and discards that value. Finally it writes the modified byte back. The port makes one access per cycle, so each operation takes five cycles. The unit holds no other processor state. The carry flag is left to the surrounding core.

The memory port is combinational: read data must be valid in the same cycle as the read strobe. The unit samples it on the closing clock edge.

Top module: `bit_tas_unit`

## Requirements
- R1: While reset is held and right after it, the unit makes no memory access, `done` is low and both flags read 0.
- R2: In idle, `start` begins an operation only if `opcode` is 8'h0E (set variant) or 8'h4E (clear variant). Any other opcode causes no memory access and leaves the flags unchanged.
- R3: An accepted operation uses five consecutive cycles, starting the cycle after `start`. Cycles 1 to 4 are reads: `op_ptr`, then `op_ptr+1`, then the target address twice. Cycle 5 is a write to the target address. The target address is {second byte, first byte}.
- R4: The set variant (8'h0E) writes first-read byte OR accumulator.
- R5: The clear variant (8'h4E) writes first-read byte AND NOT accumulator.
- R6: N becomes bit 7 of (accumulator − first-read byte) mod 256. Z becomes 1 exactly when the two are equal. Both flags take their new values at the end of the first target read and hold them until the next accepted operation.
- R7: The byte returned by the second target read has no effect on the written value or on the flags.
- R8: `done` is high in exactly the write cycle. `mem_rd` and `mem_wr` are never high together. The unit returns to idle after the write.
- R9: A `start` raised while an operation is in progress is ignored. The ongoing operation finishes unchanged and no new one follows.
- R10: The accumulator, opcode and operand pointer are captured at `start`. Changes on those inputs during the operation have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin an operation |
| opcode | input | 8 | Operation selector (8'h0E set, 8'h4E clear) |
| acc | input | 8 | Accumulator value |
| op_ptr | input | 16 | Address of the two operand address bytes |
| mem_rdata | input | 8 | Read data, valid in the cycle of `mem_rd` |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| done | output | 1 | High in the final (write) cycle |
| flag_n | output | 1 | Negative flag from the compare |
| flag_z | output | 1 | Zero flag from the compare |

## Verification
The bench uses the default 8-bit data width, which gives 16-bit addresses and the standard opcode values. At this width, an 8-bit random draw reaches every accumulator and byte value, including the modulo-256 wrap that sets N. The bench memory model returns a different byte on the second target read, so any use of that value shows up in the write data. Random operand pointers spread across the full 16-bit space, so the low/high order of the address bytes and the carry out of `op_ptr+1` are both exercised.

// File: rtl/tas_pkg.sv
package tas_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ALO  = 3'd1,
    ST_AHI  = 3'd2,
    ST_RD1  = 3'd3,
    ST_RD2  = 3'd4,
    ST_WR   = 3'd5
  } step_t;
endpackage

// File: rtl/tas_seq.sv
module tas_seq
  import tas_pkg::*;
#(
  parameter int OPC_W = 8,
  parameter logic [OPC_W-1:0] OPC_SET = 8'h0E,
  parameter logic [OPC_W-1:0] OPC_CLR = 8'h4E
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [OPC_W-1:0] opcode,
  output step_t            step,
  output logic             accept,
  output logic             is_clr
);
  step_t step_d;

  assign is_clr = (opcode == OPC_CLR);
  assign accept = (step == ST_IDLE) && start && ((opcode == OPC_SET) || is_clr);

  always_comb begin
    step_d = step;
    unique case (step)
      ST_IDLE: if (accept) step_d = ST_ALO;
      ST_ALO:  step_d = ST_AHI;
      ST_AHI:  step_d = ST_RD1;
      ST_RD1:  step_d = ST_RD2;
      ST_RD2:  step_d = ST_WR;
      ST_WR:   step_d = ST_IDLE;
      default: step_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step <= ST_IDLE;
    else        step <= step_d;
  end

  AST_WR_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (step == ST_WR) |=> (step == ST_IDLE)); // R8
  AST_FIXED_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (step == ST_RD1) |=> (step == ST_RD2)); // R3
endmodule

// File: rtl/tas_alu.sv
module tas_alu #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] acc_q,
  input  logic [DATA_W-1:0] cmp_byte,
  input  logic [DATA_W-1:0] first_byte,
  input  logic              is_clr_q,
  output logic              n_new,
  output logic              z_new,
  output logic [DATA_W-1:0] wdata
);
  logic [DATA_W-1:0] diff;

  always_comb begin
    diff  = acc_q - cmp_byte;
    n_new = diff[DATA_W-1];
    z_new = (diff == '0);
    wdata = is_clr_q ? (first_byte & ~acc_q) : (first_byte | acc_q);
  end
endmodule

// File: rtl/tas_dpath.sv
module tas_dpath
  import tas_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  step_t             step,
  input  logic              accept,
  input  logic              is_clr,
  input  logic [DATA_W-1:0] acc,
  input  logic [ADDR_W-1:0] op_ptr,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              n_new,
  input  logic              z_new,
  output logic [DATA_W-1:0] acc_q,
  output logic              is_clr_q,
  output logic [ADDR_W-1:0] ptr_q,
  output logic [ADDR_W-1:0] tgt_q,
  output logic [DATA_W-1:0] byte_q,
  output logic              n_q,
  output logic              z_q
);
  logic en_lo, en_hi, en_byte;

  assign en_lo   = (step == ST_ALO);
  assign en_hi   = (step == ST_AHI);
  assign en_byte = (step == ST_RD1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      is_clr_q <= 1'b0;
      ptr_q    <= '0;
    end else if (accept) begin
      acc_q    <= acc;
      is_clr_q <= is_clr;
      ptr_q    <= op_ptr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tgt_q[DATA_W-1:0] <= '0;
    else if (en_lo) tgt_q[DATA_W-1:0] <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tgt_q[ADDR_W-1:DATA_W] <= '0;
    else if (en_hi) tgt_q[ADDR_W-1:DATA_W] <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
      n_q    <= 1'b0;
      z_q    <= 1'b0;
    end else if (en_byte) begin
      byte_q <= mem_rdata;
      n_q    <= n_new;
      z_q    <= z_new;
    end
  end

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (step != ST_RD1) |=> $stable({n_q, z_q})); // R6
  AST_BYTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (step == ST_RD2) |=> $stable(byte_q)); // R7
endmodule

// File: rtl/bit_tas_unit.sv
module bit_tas_unit
  import tas_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] OPC_SET = 8'h0E,
  parameter logic [DATA_W-1:0] OPC_CLR = 8'h4E,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] opcode,
  input  logic [DATA_W-1:0] acc,
  input  logic [ADDR_W-1:0] op_ptr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              done,
  output logic              flag_n,
  output logic              flag_z
);
  step_t             step;
  logic              accept, is_clr, is_clr_q, n_new, z_new;
  logic [DATA_W-1:0] acc_q, byte_q, wdata;
  logic [ADDR_W-1:0] ptr_q, tgt_q;

  tas_seq #(.OPC_W(DATA_W), .OPC_SET(OPC_SET), .OPC_CLR(OPC_CLR)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .step(step), .accept(accept), .is_clr(is_clr)
  );

  tas_dpath #(.DATA_W(DATA_W)) dpath_i (
    .clk(clk), .rst_n(rst_n), .step(step), .accept(accept), .is_clr(is_clr),
    .acc(acc), .op_ptr(op_ptr), .mem_rdata(mem_rdata),
    .n_new(n_new), .z_new(z_new),
    .acc_q(acc_q), .is_clr_q(is_clr_q), .ptr_q(ptr_q), .tgt_q(tgt_q),
    .byte_q(byte_q), .n_q(flag_n), .z_q(flag_z)
  );

  tas_alu #(.DATA_W(DATA_W)) alu_i (
    .acc_q(acc_q), .cmp_byte(mem_rdata), .first_byte(byte_q),
    .is_clr_q(is_clr_q), .n_new(n_new), .z_new(z_new), .wdata(wdata)
  );

  always_comb begin
    mem_addr  = '0;
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    mem_wdata = '0;
    done      = 1'b0;
    unique case (step)
      ST_ALO: begin mem_rd = 1'b1; mem_addr = ptr_q; end
      ST_AHI: begin mem_rd = 1'b1; mem_addr = ptr_q + ADDR_W'(1); end
      ST_RD1, ST_RD2: begin mem_rd = 1'b1; mem_addr = tgt_q; end
      ST_WR: begin
        mem_wr    = 1'b1;
        mem_addr  = tgt_q;
        mem_wdata = wdata;
        done      = 1'b1;
      end
      default: ;
    endcase
  end

  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R8
  AST_DONE_IS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> mem_wr); // R8
  AST_REREAD_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && $past(mem_rd) && $past(mem_addr) == tgt_q && $past(step) == ST_RD1)
      |-> (mem_addr == $past(mem_addr))); // R3
  AST_WRITE_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (mem_addr == $past(mem_addr) && $past(mem_rd))); // R3
  AST_QUIET_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> !(mem_rd || mem_wr)); // R9
endmodule

// File: tb/bit_tas_unit_tb_top.sv
module bit_tas_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [7:0]  opcode, acc, mem_rdata, mem_wdata;
  logic [15:0] op_ptr, mem_addr;
  logic        mem_rd, mem_wr, done, flag_n, flag_z;

  logic [15:0] m_ptr, m_tgt;
  logic [7:0]  m_val;
  int          tread;
  int          n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  bit_tas_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .acc(acc),
    .op_ptr(op_ptr), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata), .done(done),
    .flag_n(flag_n), .flag_z(flag_z)
  );

  always_comb begin
    if (mem_addr == m_ptr)                 mem_rdata = m_tgt[7:0];
    else if (mem_addr == m_ptr + 16'd1)    mem_rdata = m_tgt[15:8];
    else if (mem_addr == m_tgt)            mem_rdata = (tread == 0) ? m_val : (~m_val ^ 8'h5A);
    else                                   mem_rdata = 8'hC3;
  end

  always @(posedge clk) if (mem_rd && mem_addr == m_tgt) tread <= tread + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_wr(logic [7:0] o, logic [7:0] a, logic [7:0] m);
    return (o == 8'h4E) ? (m & ~a) : (m | a);
  endfunction
  function automatic logic exp_n(logic [7:0] a, logic [7:0] m);
    logic [7:0] d = a - m;
    return d[7];
  endfunction

  task automatic run_op(input logic [7:0] o, input logic [7:0] a, input logic [15:0] p,
                        input logic [15:0] t, input logic [7:0] v, input bit disturb);
    logic [7:0] ew;
    ew = exp_wr(o, a, v);
    m_ptr = p; m_tgt = t; m_val = v; tread = 0;
    @(negedge clk);
    start = 1'b1; opcode = o; acc = a; op_ptr = p;
    @(negedge clk);
    if (disturb) begin
      start = 1'b1; opcode = (o == 8'h0E) ? 8'h4E : 8'h0E; acc = ~a; op_ptr = p ^ 16'h0F0F;
    end else start = 1'b0;
    chk(mem_rd && !mem_wr && mem_addr == p, "R3 ptr read", mem_addr, p);
    @(negedge clk);
    start = 1'b0;
    chk(mem_rd && mem_addr == p + 16'd1, "R3 ptr+1 read", mem_addr, p + 16'd1);
    @(negedge clk);
    chk(mem_rd && mem_addr == t, "R3 target read", mem_addr, t);
    @(negedge clk);
    chk(mem_rd && mem_addr == t && !done, "R3 target reread", mem_addr, t);
    chk(flag_n == exp_n(a, v) && flag_z == (a == v), "R6 flags", {flag_n, flag_z},
        {exp_n(a, v), a == v});
    @(negedge clk);
    chk(mem_wr && !mem_rd && done && mem_addr == t, "R8 write cycle done", {mem_wr, done}, 3);
    if (o == 8'h4E) chk(mem_wdata == ew, "R5 clear data R7 R10", mem_wdata, ew);
    else            chk(mem_wdata == ew, "R4 set data R7 R10", mem_wdata, ew);
    @(negedge clk);
    chk(!mem_rd && !mem_wr && !done, "R8 R9 idle after write", {mem_rd, mem_wr, done}, 0);
    chk(flag_n == exp_n(a, v) && flag_z == (a == v), "R6 flags hold", {flag_n, flag_z},
        {exp_n(a, v), a == v});
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] p, t;
    logic        fn, fz;
    void'($urandom(32'd4711));
    rst_n = 1'b0; start = 1'b0; opcode = 8'h00; acc = 8'h00; op_ptr = 16'h0;
    m_ptr = 16'h1000; m_tgt = 16'h2000; m_val = 8'h00; tread = 0;
    #35;
    chk(!mem_rd && !mem_wr && !done && !flag_n && !flag_z, "R1 in reset",
        {mem_rd, mem_wr, done, flag_n, flag_z}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(!mem_rd && !mem_wr && !done && !flag_n && !flag_z, "R1 after reset",
        {mem_rd, mem_wr, done, flag_n, flag_z}, 0);

    run_op(8'h0E, 8'h5A, 16'h1234, 16'hABCD, 8'h5A, 1'b0); // Z=1
    run_op(8'h4E, 8'h00, 16'hFFFF, 16'h8001, 8'h01, 1'b0); // N wrap, ptr+1 wraps
    run_op(8'h0E, 8'h80, 16'h0100, 16'h00FF, 8'h00, 1'b0);
    run_op(8'h4E, 8'hFF, 16'h4000, 16'h7F7F, 8'hFF, 1'b0);
    run_op(8'h0E, 8'h33, 16'h0200, 16'h0300, 8'hC1, 1'b1); // R9 R10 busy start

    // R2: unknown opcode ignored
    fn = flag_n; fz = flag_z;
    @(negedge clk); start = 1'b1; opcode = 8'h0F; acc = 8'h01;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk(!mem_rd && !mem_wr && !done, "R2 bad opcode no access", {mem_rd, mem_wr}, 0);
      @(negedge clk);
    end
    chk(flag_n == fn && flag_z == fz, "R2 flags unchanged", {flag_n, flag_z}, {fn, fz});

    for (int k = 0; k < 60; k++) begin
      p = 16'($urandom);
      do t = 16'($urandom); while (t == p || t == p + 16'd1);
      run_op(($urandom & 1) ? 8'h4E : 8'h0E, 8'($urandom), p, t,
             (k % 5 == 0) ? 8'hFF : 8'($urandom), (k % 7) == 3);
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule